// File: doc/BRIEF.md
# Staged-Expiration Watchdog with Guarded Disable

This block is a watchdog that counts expiration pulses from one of up to sixteen external timer channels and escalates through a fixed ladder of actions as the count grows. Software configures the channel, a divide ratio and a set of action enables through a small write bus. It then starts the watchdog with a command write. Each group of expirations moves the watchdog one stage further. The early stages raise interrupts so software can react. The fourth stage can pulse a debug reset, and the fifth fires a power-on reset pulse and returns the block to idle.

A running watchdog cannot be stopped by a stray write. A disable command only takes effect when the write just before it stored the unlock key. Software services the watchdog by unlocking, disabling and starting again, which begins the ladder from zero. A start command sent while the watchdog is already running has no effect.

The sequencer has six states. `ST_IDLE` moves to `ST_ARMED` on start. Each stage tick then moves it along `ST_ARMED` → `ST_WARN1` → `ST_WARN2` → `ST_WARN3` → `ST_WARN4`, and a tick in `ST_WARN4` returns it to `ST_IDLE` with the power-on reset pulse. An accepted disable returns any state to `ST_IDLE`.

Top module: `stagewd_top`

## Requirements
- R1: After reset the watchdog is idle, all five action outputs are low and a read of the configuration word returns 0.
- R2: A write to offset 0x0 stores bits 16:0 of the configuration word, which reads back on `rd_data` when `rd_addr` is 0x0. Bits above 16 read as zero. The fields are: [3:0] channel select, [11:4] period, 12 local interrupt enable, 13 fast interrupt enable, 14 remote interrupt enable, 15 debug reset enable, 16 power-on reset enable.
- R3: A write to offset 0x8 with bit 0 set starts an idle watchdog at stage 0 with its expiration count cleared. The same command while running has no effect.
- R4: While running, only pulses on the channel picked by bits 3:0 count. Every `period` counted pulses produce one stage advance, and a period of 0 behaves as 1.
- R5: `irq_local` is high while running at stage 1 or above, if bit 12 is set.
- R6: `irq_fast` (bit 13) and `irq_remote` (bit 14) are high while running at stage 2 or above.
- R7: On the stage advance into stage 4, `dbg_rst` pulses high for exactly one cycle, if bit 15 is set. It is never high together with `por_rst`.
- R8: The fifth stage advance pulses `por_rst` high for one cycle, if bit 16 is set, and returns the watchdog to idle with all interrupts low.
- R9: A write to offset 0x8 with bit 1 set disables the watchdog only if the previous write stored 0x0000C45A at offset 0xC. An accepted disable returns to idle, clears the interrupts and wins over bit 0 in the same write.
- R10: Any write other than the unlock key at offset 0xC, including a wrong key or a configuration write, cancels a pending unlock.
- R11: Disabling and starting again begins the ladder at stage 0 with a cleared expiration count.
- R12: Timer pulses received while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | DATA_W | Read data (configuration word at 0x0, zero elsewhere) |
| tmr_pulse | input | NUM_SRC | Expiration pulses from the timer channels, one bit per channel |
| irq_local | output | 1 | Local early-warning interrupt (level) |
| irq_fast | output | 1 | Local fast interrupt (level) |
| irq_remote | output | 1 | Remote interrupt (level) |
| dbg_rst | output | 1 | Debug reset request (one-cycle pulse) |
| por_rst | output | 1 | Power-on reset request (one-cycle pulse) |

## Verification
The bench targets the disable guard most of all. It sends a bare disable, an unlock followed by a configuration write, a wrong key, and an unlock separated from the disable only by idle cycles. A guard that is too loose would let the first three stop a running watchdog. A guard that is too strict would keep the last one from stopping it. Other cases are a start while running, which a faulty design would treat as a service and use to restart the ladder, and pulses on unselected channels or while idle, which a faulty design would count. Period values of 0, 1 and larger are exercised, along with a full ladder run where a wrong stage count would move the reset pulses or leave the block running after the power-on reset.

// File: rtl/stagewd_pkg.sv
package stagewd_pkg;

    // Register byte offsets (software-visible)
    localparam int unsigned OFS_CFG    = 32'h0;
    localparam int unsigned OFS_CMD    = 32'h8;
    localparam int unsigned OFS_UNLOCK = 32'hC;

    // Key that arms a single following disable command
    localparam logic [31:0] UNLOCK_KEY = 32'h0000_C45A;

    // Command bit positions
    localparam int unsigned CMD_START_BIT = 0;
    localparam int unsigned CMD_STOP_BIT  = 1;

    // Field widths
    localparam int unsigned SRC_W = 4;
    localparam int unsigned PER_W = 8;
    localparam int unsigned CFG_W = SRC_W + PER_W + 5;

    // Stage indices that trigger actions
    localparam int unsigned STAGE_DBG = 4;

    // Configuration word, MSB first: por, dbg, remote, fast, local, period, source
    typedef struct packed {
        logic             por_en;
        logic             dbg_en;
        logic             remote_en;
        logic             fast_en;
        logic             local_en;
        logic [PER_W-1:0] period;
        logic [SRC_W-1:0] src;
    } wd_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_WARN1 = 3'd2,
        ST_WARN2 = 3'd3,
        ST_WARN3 = 3'd4,
        ST_WARN4 = 3'd5
    } wd_state_e;

endpackage

// File: rtl/stagewd_expiry.sv
// Picks one timer channel and divides its pulses by the configured period.
module stagewd_expiry
    import stagewd_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] tmr_pulse,
    input  logic [SRC_W-1:0]   src,
    input  logic [PER_W-1:0]   period,
    input  logic               count_en,
    input  logic               clr,
    output logic               stage_tick
);
    localparam int unsigned LANES = 1 << SRC_W;
    localparam int unsigned CNT_W = PER_W + 1;

    logic [LANES-1:0] lanes;
    logic             sel_pulse;
    logic [PER_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] per_eff;

    // Channels beyond NUM_SRC read as permanently quiet
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g < NUM_SRC) begin : g_real
            assign lanes[g] = tmr_pulse[g];
        end else begin : g_tie
            assign lanes[g] = 1'b0;
        end
    end

    assign sel_pulse = lanes[src];
    assign cnt_inc   = {1'b0, cnt_q} + CNT_W'(1);
    assign per_eff   = (period == '0) ? CNT_W'(1) : {1'b0, period};

    // Compare with >= so a period lowered mid-run still ticks promptly
    assign stage_tick = count_en && !clr && sel_pulse && (cnt_inc >= per_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (count_en && sel_pulse) begin
            cnt_q <= stage_tick ? '0 : cnt_inc[PER_W-1:0];
        end
    end

endmodule

// File: rtl/stagewd_regs.sv
// Write bus decode: configuration storage, command strobes, unlock guard.
module stagewd_regs
    import stagewd_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output wd_cfg_t           cfg,
    output logic              cmd_start,
    output logic              cmd_stop
);
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(OFS_UNLOCK);
    localparam logic [DATA_W-1:0] KEY      = DATA_W'(UNLOCK_KEY);

    logic unlocked_q;
    logic cmd_hit;
    logic key_hit;

    assign cmd_hit = wr_en && (wr_addr == A_CMD);
    assign key_hit = wr_en && (wr_addr == A_UNLOCK) && (wr_data == KEY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg        <= '0;
            unlocked_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == A_CFG) begin
                cfg <= wd_cfg_t'(wr_data[CFG_W-1:0]);
            end
            // Every write either re-arms or consumes the guard
            unlocked_q <= key_hit;
        end
    end

    assign cmd_start = cmd_hit && wr_data[CMD_START_BIT];
    assign cmd_stop  = cmd_hit && wr_data[CMD_STOP_BIT] && unlocked_q;

    assign rd_data = (rd_addr == A_CFG) ? DATA_W'(cfg) : '0;

endmodule

// File: rtl/stagewd_fsm.sv
// Stage sequencer and action outputs.
module stagewd_fsm
    import stagewd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_start,
    input  logic    cmd_stop,
    input  logic    stage_tick,
    input  wd_cfg_t cfg,
    output logic    running,
    output logic    irq_local,
    output logic    irq_fast,
    output logic    irq_remote,
    output logic    dbg_rst,
    output logic    por_rst
);
    wd_state_e state_q, state_d;
    logic      enter_dbg;
    logic      fire_por;
    logic      warn_ge1;
    logic      warn_ge2;

    // Next-state logic: accepted disable first, then start, then ticks
    always_comb begin
        state_d   = state_q;
        enter_dbg = 1'b0;
        fire_por  = 1'b0;
        if (cmd_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (cmd_start)  state_d = ST_ARMED;
                ST_ARMED: if (stage_tick) state_d = ST_WARN1;
                ST_WARN1: if (stage_tick) state_d = ST_WARN2;
                ST_WARN2: if (stage_tick) state_d = ST_WARN3;
                ST_WARN3: begin
                    if (stage_tick) begin
                        state_d   = ST_WARN4;
                        enter_dbg = 1'b1;
                    end
                end
                ST_WARN4: begin
                    if (stage_tick) begin
                        state_d  = ST_IDLE;
                        fire_por = 1'b1;
                    end
                end
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Reset requests: registered single-cycle pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbg_rst <= 1'b0;
            por_rst <= 1'b0;
        end else begin
            dbg_rst <= enter_dbg && cfg.dbg_en;
            por_rst <= fire_por && cfg.por_en;
        end
    end

    // Interrupt levels follow the stage
    always_comb begin
        warn_ge1   = (state_q == ST_WARN1) || (state_q == ST_WARN2) ||
                     (state_q == ST_WARN3) || (state_q == ST_WARN4);
        warn_ge2   = (state_q == ST_WARN2) || (state_q == ST_WARN3) ||
                     (state_q == ST_WARN4);
        running    = (state_q != ST_IDLE);
        irq_local  = warn_ge1 && cfg.local_en;
        irq_fast   = warn_ge2 && cfg.fast_en;
        irq_remote = warn_ge2 && cfg.remote_en;
    end

endmodule

// File: rtl/stagewd_top.sv
module stagewd_top
    import stagewd_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] tmr_pulse,
    output logic               irq_local,
    output logic               irq_fast,
    output logic               irq_remote,
    output logic               dbg_rst,
    output logic               por_rst
);
    wd_cfg_t cfg;
    logic    cmd_start;
    logic    cmd_stop;
    logic    stage_tick;
    logic    running;

    stagewd_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .cfg       (cfg),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop)
    );

    stagewd_expiry #(
        .NUM_SRC (NUM_SRC)
    ) i_expiry (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_pulse  (tmr_pulse),
        .src        (cfg.src),
        .period     (cfg.period),
        .count_en   (running),
        .clr        (!running || cmd_stop),
        .stage_tick (stage_tick)
    );

    stagewd_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .stage_tick (stage_tick),
        .cfg        (cfg),
        .running    (running),
        .irq_local  (irq_local),
        .irq_fast   (irq_fast),
        .irq_remote (irq_remote),
        .dbg_rst    (dbg_rst),
        .por_rst    (por_rst)
    );

endmodule

// File: rtl/stagewd_checker.sv
module stagewd_checker
    import stagewd_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic [NUM_SRC-1:0] tmr_pulse,
    input logic               irq_local,
    input logic               irq_fast,
    input logic               irq_remote,
    input logic               dbg_rst,
    input logic               por_rst
);
    logic chk_unl;
    logic stop_wr;

    // Observer copy of the guard, built from bus traffic only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     chk_unl <= 1'b0;
        else if (wr_en) chk_unl <= (wr_addr == ADDR_W'(OFS_UNLOCK)) &&
                                   (wr_data == DATA_W'(UNLOCK_KEY));
    end

    assign stop_wr = wr_en && (wr_addr == ADDR_W'(OFS_CMD)) && wr_data[CMD_STOP_BIT];

    assert_dbg_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rst |=> !dbg_rst);

    assert_rst_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dbg_rst, por_rst}));

    assert_por_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        por_rst |=> !por_rst);

    assert_por_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        por_rst |-> !(irq_local || irq_fast || irq_remote));

    assert_locked_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_local && stop_wr && !chk_unl && (tmr_pulse == '0)) |=> irq_local);

    assert_open_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && chk_unl) |=> !(irq_local || irq_fast || irq_remote));

endmodule

bind stagewd_top stagewd_checker #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) i_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .tmr_pulse  (tmr_pulse),
    .irq_local  (irq_local),
    .irq_fast   (irq_fast),
    .irq_remote (irq_remote),
    .dbg_rst    (dbg_rst),
    .por_rst    (por_rst)
);

// File: tb/test_stagewd_top.sv
`timescale 1ns/1ps
module test_stagewd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] tmr_pulse = '0;
    logic        irq_local, irq_fast, irq_remote, dbg_rst, por_rst;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model state
    bit        m_run = 1'b0;
    int        m_stage = 0;
    int        m_cnt = 0;
    bit [16:0] m_cfg = '0;
    bit        m_unl = 1'b0;
    bit        m_dbg = 1'b0;
    bit        m_por = 1'b0;

    always #2.5 clk = ~clk;

    stagewd_top i_stagewd_top (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
        .tmr_pulse, .irq_local, .irq_fast, .irq_remote, .dbg_rst, .por_rst
    );

    function automatic bit [4:0] expected();
        return {m_por, m_dbg,
                m_run && m_stage >= 2 && m_cfg[14],
                m_run && m_stage >= 2 && m_cfg[13],
                m_run && m_stage >= 1 && m_cfg[12]};
    endfunction

    task automatic model_step(input bit we, input logic [3:0] a,
                              input logic [31:0] d, input logic [15:0] p);
        bit hit, st, sp, sel, tick;
        int per;
        hit = we && a == 4'h8;
        st  = hit && d[0];
        sp  = hit && d[1] && m_unl;
        sel = p[m_cfg[3:0]];
        per = (m_cfg[11:4] == 0) ? 1 : int'(m_cfg[11:4]);
        tick = m_run && sel && (m_cnt + 1 >= per);
        m_dbg = 1'b0;
        m_por = 1'b0;
        if (sp) begin
            m_run = 1'b0; m_stage = 0; m_cnt = 0;
        end else if (m_run) begin
            if (sel) begin
                if (tick) begin
                    m_cnt = 0;
                    if (m_stage == 4) begin
                        m_run = 1'b0; m_stage = 0; m_por = m_cfg[16];
                    end else begin
                        m_stage++;
                        if (m_stage == 4) m_dbg = m_cfg[15];
                    end
                end else begin
                    m_cnt++;
                end
            end
        end else if (st) begin
            m_run = 1'b1; m_stage = 0; m_cnt = 0;
        end
        if (we && a == 4'h0) m_cfg = d[16:0];
        if (we) m_unl = (a == 4'hC) && (d == 32'h0000_C45A);
    endtask

    task automatic check_out(input string req);
        bit [4:0] act, exp;
        act = {por_rst, dbg_rst, irq_remote, irq_fast, irq_local};
        exp = expected();
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s outputs {por,dbg,rem,fast,loc} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_rd(input string req);
        checks++;
        if (rd_data !== {15'd0, m_cfg}) begin
            failures++;
            $display("FAIL %s rd_data actual=%h expected=%h", req, rd_data, {15'd0, m_cfg});
        end
    endtask

    // One clock edge with the given stimulus; called at a falling edge
    task automatic cyc(input bit we, input logic [3:0] a, input logic [31:0] d,
                       input logic [15:0] p, input string req);
        wr_en = we; wr_addr = a; wr_data = d; tmr_pulse = p;
        model_step(we, a, d, p);
        @(negedge clk);
        wr_en = 1'b0; tmr_pulse = '0;
        check_out(req);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string req);
        cyc(1'b1, a, d, '0, req);
    endtask

    task automatic pulse(input logic [15:0] p, input string req);
        cyc(1'b0, 4'h0, 32'h0, p, req);
    endtask

    task automatic idle(input string req);
        cyc(1'b0, 4'h0, 32'h0, '0, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog timeout actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_addr = 4'h0;
        check_out("R1");
        check_rd("R1");

        // R2: upper bits dropped on readback
        wr(4'h0, 32'hFFFF_FFFF, "R2");
        #1 check_rd("R2");
        // all enables, period 1, channel 3
        wr(4'h0, 32'h0001_F013, "R2");
        #1 check_rd("R2");

        // R12: pulses while idle are ignored
        pulse(16'h0008, "R12");
        pulse(16'hFFFF, "R12");
        // R3: start
        wr(4'h8, 32'h1, "R3");
        // R4: unselected channels do not count
        pulse(16'hFFF7, "R4");
        idle("R4");
        // R5: first counted pulse -> stage 1
        pulse(16'h0008, "R5");
        // R3: start while running is ignored
        wr(4'h8, 32'h1, "R3");
        // R6: stage 2
        pulse(16'h0008, "R6");
        pulse(16'h0008, "R6");
        // R7: into stage 4, one-cycle debug reset
        pulse(16'h0008, "R7");
        idle("R7");
        // R8: fifth advance -> power-on reset, then idle
        pulse(16'h0008, "R8");
        idle("R8");
        pulse(16'h0008, "R12");

        // R9 / R10: guard
        wr(4'h8, 32'h1, "R9");
        pulse(16'h0008, "R9");
        wr(4'h8, 32'h2, "R9");
        wr(4'hC, 32'h0000_C45A, "R10");
        wr(4'h0, 32'h0001_F013, "R10");
        wr(4'h8, 32'h2, "R10");
        wr(4'hC, 32'h0000_C45B, "R10");
        wr(4'h8, 32'h2, "R10");
        wr(4'hC, 32'h0000_C45A, "R9");
        idle("R9");
        idle("R9");
        wr(4'h8, 32'h3, "R9");

        // R11: restart from zero after reaching stage 3
        wr(4'h8, 32'h1, "R11");
        repeat (3) pulse(16'h0008, "R11");
        wr(4'hC, 32'h0000_C45A, "R11");
        wr(4'h8, 32'h2, "R11");
        wr(4'h8, 32'h1, "R11");
        pulse(16'h0008, "R11");

        // R4: period 3 on channel 5, then period 0
        wr(4'hC, 32'h0000_C45A, "R4");
        wr(4'h8, 32'h2, "R4");
        wr(4'h0, 32'h0001_F035, "R4");
        wr(4'h8, 32'h1, "R4");
        repeat (4) pulse(16'h0020, "R4");
        wr(4'h0, 32'h0001_F005, "R4");
        repeat (5) pulse(16'h0020, "R4");

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 15);
            if (r < 7) begin
                if ($urandom_range(0, 2) != 0) pulse(16'(1) << m_cfg[3:0], "R4 rand");
                else pulse(16'($urandom), "R4 rand");
            end else if (r == 7) wr(4'h8, 32'h1, "R3 rand");
            else if (r == 8) wr(4'hC, 32'h0000_C45A, "R9 rand");
            else if (r == 9) wr(4'hC, $urandom, "R10 rand");
            else if (r == 10) wr(4'h8, 32'($urandom_range(2, 3)), "R9 rand");
            else if (r == 11) begin
                logic [31:0] d;
                d = {$urandom_range(0, 31) << 12} | (32'($urandom_range(0, 3)) << 4)
                    | 32'($urandom_range(0, 3)) | ($urandom & 32'hFFFE_0000);
                wr(4'h0, d, "R2 rand");
                #1 check_rd("R2 rand");
            end else idle("R5 rand");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule